// File: doc/BRIEF.md
# Byte-Wide Many-Time-Programmable Flash Behavioural Model

This block is a synthesizable, clocked stand-in for a byte-wide flash part that is rewritten only by an external programmer. A small array, sized by a parameter, is read through active-low chip-select, output-gate and write-strobe inputs. Two flags mark a supervoltage on the output-gate pin (`oe_hv`) and on address line nine (`a9_hv`). The programmer uses these flags to select programming and whole-array erase. The tri-state data bus is represented by a data word plus a drive-enable. When the drive-enable is low, the data word is held at zero.

A combinational decoder maps the pins to one of six modes:

- `MD_STANDBY`: chip-select high.
- `MD_OUT_OFF`: output gate high at a normal level.
- `MD_ARRAY_RD`: array read.
- `MD_ID_RD`: identifier read.
- `MD_PROG_SEL`: output-gate supervoltage only.
- `MD_ERASE_SEL`: output-gate and A9 supervoltage.

A controller FSM has three states: `ST_IDLE`, `ST_PROG` and `ST_ERASE`. A falling write strobe in a select mode moves it from `ST_IDLE` to `ST_PROG` or `ST_ERASE` (transition *start*). It returns to `ST_IDLE` in one of two ways:

- *complete*: the countdown expires and the result is committed.
- *abort*: a required supervoltage flag drops. The error flag is raised and nothing is committed.

`busy` models the write pulse. A program clears bits only. An erase sets every byte to 0xFF.

Top module: `mtp_flash_model`

## Requirements
- R1: With `ce_n` high, `dout_en` is 0 and `dout` is 0, whatever the other pins are doing.
- R2: With `ce_n`=0, `oe_n`=0, `oe_hv`=0 and not in identifier mode, `dout_en` is 1 and `dout` equals the array byte at `addr`. With `oe_n`=1 and `oe_hv`=0, `dout_en` is 0.
- R3: With `ce_n`=0, `oe_n`=0, `oe_hv`=0, `we_n`=1, `a9_hv`=1 and `addr[ADDR_W-1:1]`=0, `dout` is 0xBF when `addr[0]`=0 and DEV_CODE (default 0xC4) when `addr[0]`=1. If any upper address bit is set, or `we_n` is low, the array byte is read instead.
- R4: With `ce_n`=0, `oe_hv`=1 and `a9_hv`=0, a falling edge of `we_n` starts a program. When the program completes, the byte at the captured address becomes the old byte AND the captured `din`.
- R5: With `ce_n`=0, `oe_hv`=1 and `a9_hv`=1, a falling edge of `we_n` starts an erase. When the erase completes, every byte reads 0xFF, and `addr` and `din` have had no effect.
- R6: With `we_n` held high, no program or erase starts, even with the supervoltage flags set: `busy` stays 0 and the array is unchanged.
- R7: `busy` is 1 for exactly PULSE_CYC cycles, beginning in the cycle after the clock edge that sees the falling `we_n`. Falling edges on `we_n` while `busy` is 1 are ignored.
- R8: If `oe_hv` drops during a program, or `oe_hv` or `a9_hv` drops during an erase, then at the next edge `err` becomes 1, `busy` becomes 0 and the array is unchanged. `err` clears when the next operation starts.
- R9: Reset (`rst_n` low) clears `busy` and `err`.
- R10: Whenever `dout_en` is 0, `dout` is 0. Program and erase select modes never drive.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset of the controller |
| ce_n | input | 1 | Chip select, active low |
| oe_n | input | 1 | Output gate, active low |
| we_n | input | 1 | Write strobe, active low |
| oe_hv | input | 1 | Output-gate pin at supervoltage |
| a9_hv | input | 1 | Address line nine at supervoltage |
| addr | input | ADDR_W | Byte address |
| din | input | DATA_W | Write data bus |
| dout | output | DATA_W | Read data (0 when not driving) |
| dout_en | output | 1 | Data bus drive enable |
| busy | output | 1 | Program/erase pulse in progress |
| err | output | 1 | Last operation aborted by a lost supervoltage |

## Verification
The bench goes after a second program over an already programmed byte. A design that overwrites instead of ANDing would return the new data rather than the intersection. It checks that the identifier codes appear only with the upper address bits clear and the strobe high. A loose decoder would hide array bytes behind the identifier codes. It times `busy` at its first and last high cycle and one cycle later, which exposes an off-by-one pulse counter. It drops each supervoltage flag in mid-pulse and then reads the target byte. A design that commits anyway, or misses the abort, shows changed data or a clear error flag.

// File: rtl/mtp_pkg.sv
package mtp_pkg;
    typedef enum logic [2:0] {
        MD_STANDBY,
        MD_OUT_OFF,
        MD_ARRAY_RD,
        MD_ID_RD,
        MD_PROG_SEL,
        MD_ERASE_SEL
    } mode_t;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_PROG,
        ST_ERASE
    } state_t;

    localparam logic [7:0] MFR_ID = 8'hBF;
endpackage

// File: rtl/mtp_mode_decode.sv
module mtp_mode_decode
    import mtp_pkg::*;
#(
    parameter int ADDR_W = 8
) (
    input  logic              ce_n,
    input  logic              oe_n,
    input  logic              we_n,
    input  logic              oe_hv,
    input  logic              a9_hv,
    input  logic [ADDR_W-1:0] addr,
    output mode_t             mode
);
    logic upper_clear;
    assign upper_clear = (addr[ADDR_W-1:1] == '0);

    always_comb begin
        if (ce_n)
            mode = MD_STANDBY;
        else if (oe_hv)
            mode = a9_hv ? MD_ERASE_SEL : MD_PROG_SEL;
        else if (oe_n)
            mode = MD_OUT_OFF;
        else if (a9_hv && we_n && upper_clear)
            mode = MD_ID_RD;
        else
            mode = MD_ARRAY_RD;
    end
endmodule

// File: rtl/mtp_ctrl.sv
module mtp_ctrl
    import mtp_pkg::*;
#(
    parameter int ADDR_W    = 8,
    parameter int DATA_W    = 8,
    parameter int PULSE_CYC = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  mode_t             mode,
    input  logic              we_n,
    input  logic              oe_hv,
    input  logic              a9_hv,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] din,
    output logic              busy,
    output logic              err,
    output logic              wr_en,
    output logic [ADDR_W-1:0] wr_addr,
    output logic [DATA_W-1:0] wr_data,
    output logic              erase_all
);
    localparam int CNT_W = $clog2(PULSE_CYC + 1);
    localparam logic [CNT_W-1:0] CNT_LOAD = CNT_W'(PULSE_CYC - 1);

    state_t            state, nxt;
    logic [CNT_W-1:0]  cnt;
    logic              we_q;
    logic              we_fall;
    logic              start;
    logic              abort;
    logic              done;

    assign we_fall = we_q && !we_n;
    assign start   = we_fall && (state == ST_IDLE) &&
                     ((mode == MD_PROG_SEL) || (mode == MD_ERASE_SEL));
    assign done    = (cnt == '0);

    always_comb begin
        nxt   = state;
        abort = 1'b0;
        unique case (state)
            ST_IDLE: begin
                if (start)
                    nxt = (mode == MD_ERASE_SEL) ? ST_ERASE : ST_PROG;
            end
            ST_PROG: begin
                abort = !oe_hv;
                if (abort || done)
                    nxt = ST_IDLE;
            end
            ST_ERASE: begin
                abort = !oe_hv || !a9_hv;
                if (abort || done)
                    nxt = ST_IDLE;
            end
            default: nxt = ST_IDLE;
        endcase
    end

    // state register process
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state   <= ST_IDLE;
            cnt     <= '0;
            we_q    <= 1'b1;
            err     <= 1'b0;
            wr_addr <= '0;
            wr_data <= '0;
        end else begin
            state <= nxt;
            we_q  <= we_n;
            if (start) begin
                cnt     <= CNT_LOAD;
                err     <= 1'b0;
                wr_addr <= addr;
                wr_data <= din;
            end else if (state != ST_IDLE) begin
                if (abort)
                    err <= 1'b1;
                if (!done)
                    cnt <= cnt - 1'b1;
            end
        end
    end

    // output process
    always_comb begin
        busy      = 1'b0;
        wr_en     = 1'b0;
        erase_all = 1'b0;
        unique case (state)
            ST_IDLE: ;
            ST_PROG: begin
                busy  = 1'b1;
                wr_en = done && !abort;
            end
            ST_ERASE: begin
                busy      = 1'b1;
                erase_all = done && !abort;
            end
            default: ;
        endcase
    end

    logic [CNT_W:0] busy_run;
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            busy_run <= '0;
        else
            busy_run <= busy ? busy_run + 1'b1 : '0;
    end

    // R7
    start_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        start |=> busy);

    // R7
    busy_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> (busy_run < (CNT_W+1)'(PULSE_CYC)));

    // R8
    err_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(err) |-> $past(busy));
endmodule

// File: rtl/mtp_array.sv
module mtp_array #(
    parameter int ADDR_W = 8,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              erase_all,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [DATA_W-1:0] rd_data
);
    localparam int DEPTH = 1 << ADDR_W;

    logic [DATA_W-1:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (erase_all) begin
            for (int i = 0; i < DEPTH; i++)
                mem[i] <= '1;
        end else if (wr_en) begin
            mem[wr_addr] <= mem[wr_addr] & wr_data;
        end
    end

    assign rd_data = mem[rd_addr];
endmodule

// File: rtl/mtp_read_mux.sv
module mtp_read_mux
    import mtp_pkg::*;
#(
    parameter int          ADDR_W   = 8,
    parameter int          DATA_W   = 8,
    parameter logic [7:0]  DEV_CODE = 8'hC4
) (
    input  mode_t             mode,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] rd_data,
    output logic [DATA_W-1:0] dout,
    output logic              dout_en
);
    always_comb begin
        dout    = '0;
        dout_en = 1'b0;
        unique case (mode)
            MD_ARRAY_RD: begin
                dout_en = 1'b1;
                dout    = rd_data;
            end
            MD_ID_RD: begin
                dout_en = 1'b1;
                dout    = DATA_W'(addr[0] ? DEV_CODE : MFR_ID);
            end
            MD_STANDBY, MD_OUT_OFF, MD_PROG_SEL, MD_ERASE_SEL: ;
            default: ;
        endcase
    end
endmodule

// File: rtl/mtp_flash_model.sv
module mtp_flash_model
    import mtp_pkg::*;
#(
    parameter int         ADDR_W    = 8,
    parameter int         DATA_W    = 8,
    parameter int         PULSE_CYC = 4,
    parameter logic [7:0] DEV_CODE  = 8'hC4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ce_n,
    input  logic              oe_n,
    input  logic              we_n,
    input  logic              oe_hv,
    input  logic              a9_hv,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] din,
    output logic [DATA_W-1:0] dout,
    output logic              dout_en,
    output logic              busy,
    output logic              err
);
    mode_t             mode;
    logic              wr_en;
    logic              erase_all;
    logic [ADDR_W-1:0] wr_addr;
    logic [DATA_W-1:0] wr_data;
    logic [DATA_W-1:0] rd_data;

    mtp_mode_decode #(.ADDR_W(ADDR_W)) dec_i (
        .ce_n(ce_n), .oe_n(oe_n), .we_n(we_n),
        .oe_hv(oe_hv), .a9_hv(a9_hv), .addr(addr), .mode(mode)
    );

    mtp_ctrl #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .PULSE_CYC(PULSE_CYC)) ctrl_i (
        .clk(clk), .rst_n(rst_n), .mode(mode), .we_n(we_n),
        .oe_hv(oe_hv), .a9_hv(a9_hv), .addr(addr), .din(din),
        .busy(busy), .err(err), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .erase_all(erase_all)
    );

    mtp_array #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) arr_i (
        .clk(clk), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .erase_all(erase_all), .rd_addr(addr), .rd_data(rd_data)
    );

    mtp_read_mux #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .DEV_CODE(DEV_CODE)) mux_i (
        .mode(mode), .addr(addr), .rd_data(rd_data),
        .dout(dout), .dout_en(dout_en)
    );

    // R1
    standby_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ce_n |-> !dout_en);

    // R10
    hiz_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !dout_en |-> (dout == '0));

    // R2
    drive_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        dout_en |-> (!ce_n && !oe_n && !oe_hv));
endmodule

// File: tb/mtp_flash_model_tb_top.sv
module mtp_flash_model_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int PULSE_CYC  = 4;
    localparam int NVEC       = 11;

    logic       clk = 1'b0;
    logic       rst_n;
    logic       ce_n, oe_n, we_n, oe_hv, a9_hv;
    logic [7:0] addr, din;
    logic [7:0] dout;
    logic       dout_en, busy, err;

    int n_chk = 0;
    int n_bad = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    mtp_flash_model #(.ADDR_W(8), .DATA_W(8), .PULSE_CYC(PULSE_CYC), .DEV_CODE(8'hC4)) dut_i (
        .clk(clk), .rst_n(rst_n), .ce_n(ce_n), .oe_n(oe_n), .we_n(we_n),
        .oe_hv(oe_hv), .a9_hv(a9_hv), .addr(addr), .din(din),
        .dout(dout), .dout_en(dout_en), .busy(busy), .err(err)
    );

    // {ce_n, oe_n, we_n, oe_hv, a9_hv, addr, exp_en, exp_dout}
    localparam logic [21:0] VECS [NVEC] = '{
        {5'b10100, 8'h05, 1'b0, 8'h00},
        {5'b10011, 8'h05, 1'b0, 8'h00},
        {5'b00100, 8'h05, 1'b1, 8'h3C},
        {5'b00100, 8'h02, 1'b1, 8'hA5},
        {5'b00100, 8'h07, 1'b1, 8'hFF},
        {5'b01100, 8'h05, 1'b0, 8'h00},
        {5'b00101, 8'h00, 1'b1, 8'hBF},
        {5'b00101, 8'h01, 1'b1, 8'hC4},
        {5'b00101, 8'h02, 1'b1, 8'hA5},
        {5'b00001, 8'h01, 1'b1, 8'hFF},
        {5'b00110, 8'h05, 1'b0, 8'h00}
    };

    task automatic chk(input string tag, input logic [8:0] act, input logic [8:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic idle_pins();
        ce_n = 1'b1; oe_n = 1'b1; we_n = 1'b1; oe_hv = 1'b0; a9_hv = 1'b0;
    endtask

    task automatic rd(input logic [7:0] a, input logic [7:0] exp, input string tag);
        @(negedge clk);
        ce_n = 1'b0; oe_n = 1'b0; we_n = 1'b1; oe_hv = 1'b0; a9_hv = 1'b0; addr = a;
        #1;
        chk(tag, {dout_en, dout}, {1'b1, exp});
    endtask

    // full program/erase pulse with busy timing checks
    task automatic pulse_op(input logic is_erase, input logic [7:0] a, input logic [7:0] d);
        @(negedge clk);
        ce_n = 1'b0; oe_n = 1'b1; we_n = 1'b1; oe_hv = 1'b1; a9_hv = is_erase;
        addr = a; din = d;
        @(negedge clk);
        we_n = 1'b0;
        @(negedge clk);
        chk("R7 busy first cycle", {8'h0, busy}, 9'h1);
        chk("R8 err cleared at start", {8'h0, err}, 9'h0);
        we_n = 1'b1;
        @(negedge clk);
        we_n = 1'b0;   // extra falling edge while busy: ignored (R7)
        repeat (PULSE_CYC - 2) @(negedge clk);
        chk("R7 busy last cycle", {8'h0, busy}, 9'h1);
        @(negedge clk);
        chk("R7 busy released", {8'h0, busy}, 9'h0);
        idle_pins();
    endtask

    task automatic abort_op(input logic is_erase, input logic drop_a9, input logic [7:0] a,
                            input logic [7:0] d, input string tag);
        @(negedge clk);
        ce_n = 1'b0; oe_n = 1'b1; we_n = 1'b1; oe_hv = 1'b1; a9_hv = is_erase;
        addr = a; din = d;
        @(negedge clk);
        we_n = 1'b0;
        @(negedge clk);
        if (drop_a9) a9_hv = 1'b0; else oe_hv = 1'b0;
        @(negedge clk);
        chk({tag, " err"}, {8'h0, err}, 9'h1);
        chk({tag, " busy"}, {8'h0, busy}, 9'h0);
        idle_pins();
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        rst_n = 1'b0; idle_pins(); addr = '0; din = '0;
        repeat (3) @(negedge clk);
        chk("R9 busy in reset", {8'h0, busy}, 9'h0);
        chk("R9 err in reset", {8'h0, err}, 9'h0);
        rst_n = 1'b1;

        // R5: erase with arbitrary addr/din
        pulse_op(1'b1, 8'h33, 8'h12);
        rd(8'h00, 8'hFF, "R5 erased byte 0");
        rd(8'h33, 8'hFF, "R5 erased byte 0x33");
        rd(8'hFF, 8'hFF, "R5 erased byte 0xFF");

        // R4: programs
        pulse_op(1'b0, 8'h02, 8'hA5);
        pulse_op(1'b0, 8'h05, 8'h3C);
        rd(8'h05, 8'h3C, "R4 programmed byte");

        // table walk: R1 R2 R3 R10
        for (int i = 0; i < NVEC; i++) begin
            @(negedge clk);
            {ce_n, oe_n, we_n, oe_hv, a9_hv} = VECS[i][21:17];
            addr = VECS[i][16:9];
            #1;
            chk($sformatf("R1/R2/R3/R10 vector %0d", i), {dout_en, dout}, VECS[i][8:0]);
        end
        idle_pins();

        // R4: second program only clears bits
        pulse_op(1'b0, 8'h05, 8'hF0);
        rd(8'h05, 8'h30, "R4 AND of old and new");

        // R6: supervoltage with strobe held high
        @(negedge clk);
        ce_n = 1'b0; oe_hv = 1'b1; a9_hv = 1'b1; we_n = 1'b1;
        repeat (PULSE_CYC + 2) @(negedge clk);
        chk("R6 no busy while strobe high", {8'h0, busy}, 9'h0);
        idle_pins();
        rd(8'h05, 8'h30, "R6 array untouched");

        // R8: aborted program and erase
        abort_op(1'b0, 1'b0, 8'h02, 8'h00, "R8 program oe drop");
        rd(8'h02, 8'hA5, "R8 program not committed");
        abort_op(1'b1, 1'b1, 8'h00, 8'h00, "R8 erase a9 drop");
        rd(8'h05, 8'h30, "R8 erase not committed");

        // R8: err clears on next start, then normal program
        pulse_op(1'b0, 8'h07, 8'hAA);
        chk("R8 err stays clear", {8'h0, err}, 9'h0);
        rd(8'h07, 8'hAA, "R4 program after abort");

        // R5: final erase restores 0xFF
        pulse_op(1'b1, 8'h07, 8'h00);
        rd(8'h02, 8'hFF, "R5 re-erase byte 2");
        rd(8'h07, 8'hFF, "R5 re-erase byte 7");

        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule